// File: doc/BRIEF.md
# Interrupt Request Input Stage

This block is the front end for the request lines of an eight-input programmable interrupt controller. Each line owns a small cell that turns the raw request pin into a pending-request bit. That bit feeds a priority resolver, which lies outside this block. A single trigger-mode bit applies to all lines and is captured when the initialization strobe is asserted. In edge mode, a line becomes pending only after its pin has risen from low. In level mode, a line is pending whenever its pin is high.

The pending bit acts as a transparent latch, built here from a flop. Outside acknowledge and poll sequences, it follows the qualified request one clock later. While the freeze input is high, the pending bit holds its value. An acknowledge pulse clears the pending bit of its line. The initialization strobe clears every cell. Mask bits gate only the output toward the resolver and leave the pending bits as they are.

Top module: `irq_in_stage`

## Requirements
- R1: While synchronous reset is asserted, `pend` and `masked_req` are all zero at the next clock edge, and edge mode is selected.
- R2: The trigger mode is taken from `trig_level` only on a clock edge where `init_wr` is 1 (1 = level, 0 = edge). At every other edge a change on `trig_level` has no effect.
- R3: A clock edge with `init_wr` high clears every `pend` bit. It also disarms every edge detector, so in edge mode a pin must be seen low before it can raise a request again.
- R4: In level mode, with freeze low and no acknowledge or init on that line, `pend[i]` equals the `req_pin[i]` value sampled at the previous edge.
- R5: In edge mode, `pend[i]` sets only when the pin is high and the line was armed by seeing its pin low at an earlier edge. It drops again if the pin falls before acknowledge.
- R6: In edge mode, after an acknowledge the line raises no new request while its pin stays high. It needs a low then a high on the pin first.
- R7: In level mode, a pin still high after its acknowledge raises `pend[i]` again on the following edge (a second interrupt).
- R8: While `freeze` is high, `pend` holds its value whatever the pins do, except on lines being acknowledged or during init.
- R9: `ack_clr[i]` clears `pend[i]` at the next edge, even during freeze. Other lines are unaffected.
- R10: `masked_req[i]` is `pend[i]` AND NOT `mask[i]`, combinationally. Masking never clears `pend[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_pin | input | N_LINES | Raw request pins |
| init_wr | input | 1 | Initialization strobe: master clear and mode capture |
| trig_level | input | 1 | Trigger mode to capture: 1 level, 0 edge |
| freeze | input | 1 | Holds the pending bits during acknowledge/poll |
| ack_clr | input | N_LINES | Per-line acknowledge clear |
| mask | input | N_LINES | Per-line mask |
| pend | output | N_LINES | Latched pending requests |
| masked_req | output | N_LINES | Pending requests that are not masked |

## Verification
The hardest case to reach is edge-mode re-arming. A line disarmed by init or by acknowledge must ignore a pin that stays high. To reach this, the stimulus keeps pins high across an init strobe and across an acknowledge, and checks that nothing becomes pending. It then drops and raises the pin to show the request returns. Level-mode re-triggering is reached by acknowledging a line while its pin stays high. Freeze is combined with an acknowledge and with a falling pin to separate hold from clear.

// File: rtl/irq_in_pkg.sv
// Package: shared types for the interrupt request input stage.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_in_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

endpackage

// File: rtl/irq_edge_arm.sv
// Module: irq_edge_arm
// Edge-detect arming flop for one request line. It is armed when the pin
// is seen low. It is disarmed by the master clear or by the line's acknowledge.
// Assumes: pin is synchronous to clk. A low pin re-arms even during an acknowledge.
module irq_edge_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic clr_init,
    input  logic ack,
    output logic armed
);

    logic armed_q;

    // Arming state: clear, re-arm on low, disarm on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (clr_init) begin
            armed_q <= 1'b0;
        end else if (!pin) begin
            armed_q <= 1'b1;
        end else if (ack) begin
            armed_q <= 1'b0;
        end
    end

    assign armed = armed_q;

    // R6
    rearm_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin && !clr_init) |=> armed);

    // R6
    disarm_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && pin) |=> !armed);

    // R3
    disarm_on_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_init |=> !armed);

endmodule

// File: rtl/irq_req_hold.sv
// Module: irq_req_hold
// Flop-based equivalent of a transparent request latch. It follows the
// qualified request one clock later unless frozen. Acknowledge and master
// clear reset it, and both override the freeze.
// Assumes: freeze is high only during acknowledge or poll sequences.
module irq_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic qual,
    input  logic freeze,
    input  logic clr_init,
    input  logic ack,
    output logic pend
);

    logic pend_q;

    // Pending bit: clear first, then hold while frozen, else follow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (clr_init || ack) begin
            pend_q <= 1'b0;
        end else if (!freeze) begin
            pend_q <= qual;
        end
    end

    assign pend = pend_q;

    // R8
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !ack && !clr_init) |=> $stable(pend));

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !pend);

    // R3
    init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_init |=> !pend);

endmodule

// File: rtl/irq_line_cell.sv
// Module: irq_line_cell
// One request line: qualifies the pin by the trigger mode (the edge arming
// flop is bypassed in level mode), latches it, and applies the mask.
// Assumes: mode changes only together with a master clear.
module irq_line_cell
    import irq_in_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  trig_mode_e mode,
    input  logic       clr_init,
    input  logic       freeze,
    input  logic       ack,
    input  logic       mask_bit,
    output logic       pend,
    output logic       masked
);

    logic armed;
    logic qual;

    irq_edge_arm u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (pin),
        .clr_init (clr_init),
        .ack      (ack),
        .armed    (armed)
    );

    // Request qualification: level passes the pin, edge needs arming.
    always_comb begin
        if (mode == TRIG_LEVEL) begin
            qual = pin;
        end else begin
            qual = pin & armed;
        end
    end

    irq_req_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual     (qual),
        .freeze   (freeze),
        .clr_init (clr_init),
        .ack      (ack),
        .pend     (pend)
    );

    // Masked request toward the priority resolver.
    always_comb begin
        masked = pend & ~mask_bit;
    end

    // R4
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_LEVEL && !freeze && !ack && !clr_init) |=> (pend == $past(pin)));

    // R5
    edge_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_EDGE && !pend) |=> (!pend || ($past(armed) && $past(pin))));

endmodule

// File: rtl/irq_in_stage.sv
// Module: irq_in_stage
// Top of the request input stage. It holds the trigger mode captured at
// init and instantiates one cell per line.
// Assumes: init_wr is a single-cycle strobe of the first initialization write.
module irq_in_stage
    import irq_in_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_pin,
    input  logic               init_wr,
    input  logic               trig_level,
    input  logic               freeze,
    input  logic [N_LINES-1:0] ack_clr,
    input  logic [N_LINES-1:0] mask,
    output logic [N_LINES-1:0] pend,
    output logic [N_LINES-1:0] masked_req
);

    trig_mode_e mode_q;

    // Trigger mode register: loaded only by the init strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= TRIG_EDGE;
        end else if (init_wr) begin
            mode_q <= trig_mode_e'(trig_level);
        end
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        irq_line_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (req_pin[g]),
            .mode     (mode_q),
            .clr_init (init_wr),
            .freeze   (freeze),
            .ack      (ack_clr[g]),
            .mask_bit (mask[g]),
            .pend     (pend[g]),
            .masked   (masked_req[g])
        );
    end

    // R2
    mode_only_on_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_wr |=> $stable(mode_q));

    // R2
    mode_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> (mode_q == trig_mode_e'($past(trig_level))));

    // R10
    mask_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0 && !init_wr && !freeze && ack_clr == '0 && $past(pend) == pend)
        |-> ((masked_req | (pend & mask)) == pend));

endmodule

// File: tb/irq_in_stage_bench.sv
`timescale 1ns/1ps
module irq_in_stage_bench;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_pin = '0;
    logic         init_wr = 1'b0;
    logic         trig_level = 1'b0;
    logic         freeze = 1'b0;
    logic [N-1:0] ack_clr = '0;
    logic [N-1:0] mask = '0;
    logic [N-1:0] pend;
    logic [N-1:0] masked_req;

    irq_in_stage #(.N_LINES(N)) u_irq_in_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_pin    (req_pin),
        .init_wr    (init_wr),
        .trig_level (trig_level),
        .freeze     (freeze),
        .ack_clr    (ack_clr),
        .mask       (mask),
        .pend       (pend),
        .masked_req (masked_req)
    );

    always #2 clk = ~clk;

    typedef struct {
        int           due;
        logic [N-1:0] ep;
        logic [N-1:0] em;
        string        tag;
    } exp_t;

    exp_t sbq[$];
    int   pcount = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    task automatic chk(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: pops expectations due at this edge and compares them.
    always @(posedge clk) begin
        pcount++;
        #1;
        while (sbq.size() > 0 && sbq[0].due <= pcount) begin
            exp_t it;
            it = sbq.pop_front();
            chk(it.tag, "pend", pend, it.ep);
            chk(it.tag, "masked_req", masked_req, it.em);
        end
    end

    // Driver: applies one cycle of stimulus and queues its expected result.
    task automatic step(logic [N-1:0] pin, logic [N-1:0] ack, logic frz,
                        logic ini, logic lvl, logic [N-1:0] msk,
                        logic [N-1:0] ep, string tag);
        exp_t it;
        @(negedge clk);
        req_pin    = pin;
        ack_clr    = ack;
        freeze     = frz;
        init_wr    = ini;
        trig_level = lvl;
        mask       = msk;
        it.due = pcount + 1;
        it.ep  = ep;
        it.em  = ep & ~msk;
        it.tag = tag;
        sbq.push_back(it);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "pend", pend, '0);
        chk("R1", "masked_req", masked_req, '0);
        rst_n = 1'b1;

        // Edge mode after reset.
        step(8'h00, 8'h00, 0, 0, 0, 8'h00, 8'h00, "R5 arm");
        step(8'h01, 8'h00, 0, 0, 0, 8'h00, 8'h01, "R5 rise");
        step(8'h03, 8'h00, 0, 1, 0, 8'h00, 8'h00, "R3 init clear");
        step(8'h03, 8'h00, 0, 0, 0, 8'h00, 8'h00, "R3 disarmed");
        step(8'h02, 8'h00, 0, 0, 0, 8'h00, 8'h00, "R5 low arms");
        step(8'h03, 8'h00, 0, 0, 0, 8'h00, 8'h01, "R5 one line edge");
        step(8'h01, 8'h00, 0, 0, 0, 8'h00, 8'h01, "R5 hold high");
        step(8'h00, 8'h00, 0, 0, 0, 8'h00, 8'h00, "R5 drop");
        step(8'h01, 8'h00, 0, 0, 0, 8'h00, 8'h01, "R5 rise again");
        step(8'h01, 8'h01, 0, 0, 0, 8'h00, 8'h00, "R9 ack");
        step(8'h01, 8'h00, 0, 0, 0, 8'h00, 8'h00, "R6 no retrigger");
        step(8'h00, 8'h00, 0, 0, 0, 8'h00, 8'h00, "R6 low");
        step(8'h01, 8'h00, 0, 0, 0, 8'h00, 8'h01, "R6 new edge");
        // Freeze.
        step(8'h05, 8'h00, 1, 0, 0, 8'h00, 8'h01, "R8 freeze new pin");
        step(8'h04, 8'h00, 1, 0, 0, 8'h00, 8'h01, "R8 freeze pin drop");
        step(8'h04, 8'h01, 1, 0, 0, 8'h00, 8'h00, "R9 ack in freeze");
        step(8'h04, 8'h00, 0, 0, 0, 8'h00, 8'h04, "R8 unfreeze");
        // Mask.
        step(8'h04, 8'h00, 0, 0, 0, 8'h04, 8'h04, "R10 masked");
        step(8'h04, 8'h00, 0, 0, 0, 8'h00, 8'h04, "R10 unmasked");
        // Mode port without init.
        step(8'h04, 8'h04, 0, 0, 1, 8'h00, 8'h00, "R2 ack");
        step(8'h04, 8'h00, 0, 0, 1, 8'h00, 8'h00, "R2 still edge");
        // Level mode.
        step(8'h04, 8'h00, 0, 1, 1, 8'h00, 8'h00, "R3 init level");
        step(8'h0C, 8'h00, 0, 0, 0, 8'h00, 8'h0C, "R4 follow");
        step(8'h08, 8'h00, 0, 0, 0, 8'h00, 8'h08, "R4 follow low");
        step(8'h08, 8'h08, 0, 0, 0, 8'h00, 8'h00, "R7 ack");
        step(8'h08, 8'h00, 0, 0, 0, 8'h00, 8'h08, "R7 second interrupt");
        step(8'h80, 8'h00, 0, 0, 0, 8'h00, 8'h80, "R4 switch line");
        // Back to edge mode.
        step(8'h00, 8'h00, 0, 1, 0, 8'h00, 8'h00, "R2 init edge");
        step(8'h00, 8'h00, 0, 0, 0, 8'h00, 8'h00, "R5 arm all");
        step(8'hFF, 8'h00, 0, 0, 0, 8'h00, 8'hFF, "R5 all rise");
        step(8'hFF, 8'h0F, 0, 0, 0, 8'hA0, 8'hF0, "R9 partial ack");
        step(8'hFF, 8'h00, 0, 0, 0, 8'h00, 8'hF0, "R6 acked stay clear");

        @(negedge clk);
        repeat (3) @(posedge clk);
        #1;
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule